// File: doc/BRIEF.md
# Bus Bridge Show Cycle Controller

This block sits at the seam between a fast local bus and a slower system bus. It watches write accesses on the local bus. When one is acknowledged, it copies that write onto the system bus as a show cycle, so that debug equipment attached there can see it. Only one access is handled at a time. From the cycle after an access is accepted, the block holds the local bus so that no other local master can start a transfer while the mirror is still running.

The block takes the address, the write data and the attributes at the local address acknowledge. It takes the data-error status at the local termination. A qualify input, sampled with the acknowledge, selects whether the access is mirrored. For a qualifying access, the block requests the system bus as a master. It keeps the request up for a minimum number of clocks, waits a fixed number of clocks after it wins the bus, and then finishes both the address phase and the data phase itself, acting as the slave. The data phase waits until any earlier data phase on the system bus has ended, so that data phases finish in order.

The system side can refuse a show cycle with a no-show indicator. The block then drops its request for one clock and starts the request sequence again for the same captured access. A non-qualifying access releases the local bus without touching the system bus.

Top module: `show_cycle_bridge`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. In the cycle after reset, `locHold`, `sysReq`, `sysAddrValid`, `sysAddrAck`, `sysDataAck` and `sysDataErr` are 0, and `sysAddr`, `sysAttr` and `sysData` are 0.
- R2: `locHold` is 1 from the clock after an accepted access until the processing ends. Processing ends one clock after the access terminates (non-qualifying) or one clock after the show-cycle data acknowledge (qualifying).
- R3: An access that is presented with `locValid`=1 but `locAddrAck`=0 (a retry) is not accepted and leaves `locHold` at 0. Only an access seen with both `locValid`=1 and `locAddrAck`=1 is captured.
- R4: The address, attributes and write data driven on the system bus are the values present at the accepted address acknowledge, even if the local inputs change afterwards. `sysAddr` and `sysAttr` are driven only while `sysAddrValid`=1, and `sysData` only during the data phase. At all other times they are 0.
- R5: The `locDataErr` value sampled in the cycle where `locDone`=1 is driven on `sysDataErr` together with `sysDataAck`. `sysDataErr` is never 1 without `sysDataAck`.
- R6: Once the request starts, `sysReq` stays at 1 for at least MIN_REQ_CYC (default 2) clocks. The block does not leave the request phase earlier, even if `sysGrant` is 1 in the first cycle.
- R7: After the grant has been taken, the block waits GRANT_WAIT_CYC (default 2) clocks, with `sysReq` still 1, before the single-cycle address phase. In the address phase `sysAddrValid`=1 and `sysAddrAck`=1.
- R8: If `sysNoShow`=1 while `sysReq`=1, `sysReq` goes to 0 for exactly one clock. The request sequence then restarts for the same captured access.
- R9: `sysDataAck` is 0 in any cycle where `sysDataBusy`=1. The data phase stays open until `sysDataBusy`=0.
- R10: An accepted access with `locQualify`=0 produces no system-bus activity: `sysReq`, `sysAddrValid` and `sysDataAck` stay 0.
- R11: While the block is busy, a new local access with `locValid`=1 and `locAddrAck`=1 is ignored. The show cycle in progress keeps the address first captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| locValid | input | 1 | A local write access is in its address phase |
| locAddrAck | input | 1 | Local address acknowledge (0 means retry) |
| locAddr | input | ADDR_W | Local access address |
| locData | input | DATA_W | Local write data |
| locAttr | input | ATTR_W | Local address attributes |
| locQualify | input | 1 | Access is to be mirrored; sampled with the acknowledge |
| locDone | input | 1 | Local access termination |
| locDataErr | input | 1 | Data-error status, valid with `locDone` |
| locHold | output | 1 | Local bus request held by the bridge |
| sysReq | output | 1 | System bus request |
| sysGrant | input | 1 | System bus grant |
| sysNoShow | input | 1 | System side vetoes the show cycle |
| sysDataBusy | input | 1 | An earlier system data phase is still open |
| sysAddrValid | output | 1 | Show-cycle address phase start |
| sysAddrAck | output | 1 | Address acknowledge driven by the bridge as slave |
| sysAddr | output | ADDR_W | Show-cycle address |
| sysAttr | output | ATTR_W | Show-cycle attributes |
| sysData | output | DATA_W | Show-cycle data |
| sysDataAck | output | 1 | Data acknowledge driven by the bridge as slave |
| sysDataErr | output | 1 | Data error, valid with `sysDataAck` |

## Verification
Any error in the sequencing state shows up at the ports within a clock. Examples are a request phase that is cut short, a skipped wait, a missed back-off or a data phase that ignores the busy input. Each one moves `sysReq`, `sysAddrValid` or `sysDataAck` by a cycle against the reference model. Errors in the capture registers only appear once the address or data phase is driven. So each test pushes changed local inputs, retried accesses and overlapping accesses through to the end of a full show cycle. A wrong release point shows directly on `locHold` in the clock after termination or after the data acknowledge.

// File: rtl/show_cycle_pkg.sv
package show_cycle_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TERM,
    ST_REQ,
    ST_WAIT,
    ST_ADDR,
    ST_DATA,
    ST_BACKOFF,
    ST_RELEASE
  } scState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capAccess;  // latch address, data, attributes
    logic capErr;     // latch termination error status
    logic driveAddr;  // present captured address/attributes
    logic driveData;  // present captured data
    logic ackData;    // data phase acknowledged this cycle
  } scStrobes_t;

endpackage

// File: rtl/show_cycle_ctrl.sv
module show_cycle_ctrl
  import show_cycle_pkg::*;
#(
  parameter int MIN_REQ_CYC    = 2,
  parameter int GRANT_WAIT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       locValid,
  input  logic       locAddrAck,
  input  logic       locQualify,
  input  logic       locDone,
  input  logic       sysGrant,
  input  logic       sysNoShow,
  input  logic       sysDataBusy,
  output scStrobes_t ctl,
  output logic       locHold,
  output logic       sysReq,
  output logic       sysAddrValid,
  output logic       sysAddrAck,
  output logic       sysDataAck
);

  localparam int REQ_CNT_W  = $clog2(MIN_REQ_CYC + 1);
  localparam int WAIT_CNT_W = $clog2(GRANT_WAIT_CYC + 1);
  localparam logic [REQ_CNT_W-1:0]  REQ_LAST  = REQ_CNT_W'(MIN_REQ_CYC - 1);
  localparam logic [WAIT_CNT_W-1:0] WAIT_LAST = WAIT_CNT_W'(GRANT_WAIT_CYC - 1);

  scState_e state, nextState;
  logic [REQ_CNT_W-1:0]  reqCnt;
  logic [WAIT_CNT_W-1:0] waitCnt;
  logic qualQ;
  logic accept;
  logic termNow;
  logic qualNow;

  assign accept  = (state == ST_IDLE) && locValid && locAddrAck;
  assign termNow = (accept && locDone) || ((state == ST_TERM) && locDone);
  assign qualNow = accept ? locQualify : qualQ;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (locDone) nextState = locQualify ? ST_REQ : ST_RELEASE;
          else         nextState = ST_TERM;
        end
      end
      ST_TERM: begin
        if (locDone) nextState = qualNow ? ST_REQ : ST_RELEASE;
      end
      ST_REQ: begin
        if (sysNoShow)                          nextState = ST_BACKOFF;
        else if (sysGrant && reqCnt >= REQ_LAST) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (sysNoShow)              nextState = ST_BACKOFF;
        else if (waitCnt == WAIT_LAST) nextState = ST_ADDR;
      end
      ST_ADDR:    nextState = ST_DATA;
      ST_DATA:    if (!sysDataBusy) nextState = ST_RELEASE;
      ST_BACKOFF: nextState = ST_REQ;
      ST_RELEASE: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      reqCnt  <= '0;
      waitCnt <= '0;
      qualQ   <= 1'b0;
    end else begin
      state <= nextState;
      if (state != ST_REQ)        reqCnt <= '0;
      else if (reqCnt != REQ_LAST) reqCnt <= reqCnt + 1'b1;
      if (state != ST_WAIT)         waitCnt <= '0;
      else if (waitCnt != WAIT_LAST) waitCnt <= waitCnt + 1'b1;
      if (accept) qualQ <= locQualify;
    end
  end

  always_comb begin
    ctl.capAccess = accept;
    ctl.capErr    = termNow;
    ctl.driveAddr = (state == ST_ADDR);
    ctl.driveData = (state == ST_DATA);
    ctl.ackData   = (state == ST_DATA) && !sysDataBusy;
  end

  assign locHold      = (state != ST_IDLE);
  assign sysReq       = (state == ST_REQ) || (state == ST_WAIT);
  assign sysAddrValid = (state == ST_ADDR);
  assign sysAddrAck   = (state == ST_ADDR);
  assign sysDataAck   = ctl.ackData;

endmodule

// File: rtl/show_cycle_datapath.sv
module show_cycle_datapath
  import show_cycle_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  scStrobes_t        ctl,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locData,
  input  logic [ATTR_W-1:0] locAttr,
  input  logic              locDataErr,
  output logic [ADDR_W-1:0] sysAddr,
  output logic [ATTR_W-1:0] sysAttr,
  output logic [DATA_W-1:0] sysData,
  output logic              sysDataErr
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [ATTR_W-1:0] attrQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      dataQ <= '0;
      attrQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (ctl.capAccess) begin
        addrQ <= locAddr;
        dataQ <= locData;
        attrQ <= locAttr;
      end
      if (ctl.capErr) errQ <= locDataErr;
    end
  end

  assign sysAddr    = ctl.driveAddr ? addrQ : '0;
  assign sysAttr    = ctl.driveAddr ? attrQ : '0;
  assign sysData    = ctl.driveData ? dataQ : '0;
  assign sysDataErr = ctl.ackData & errQ;

endmodule

// File: rtl/show_cycle_bridge.sv
module show_cycle_bridge
  import show_cycle_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int ATTR_W         = 4,
  parameter int MIN_REQ_CYC    = 2,
  parameter int GRANT_WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              locValid,
  input  logic              locAddrAck,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locData,
  input  logic [ATTR_W-1:0] locAttr,
  input  logic              locQualify,
  input  logic              locDone,
  input  logic              locDataErr,
  output logic              locHold,
  output logic              sysReq,
  input  logic              sysGrant,
  input  logic              sysNoShow,
  input  logic              sysDataBusy,
  output logic              sysAddrValid,
  output logic              sysAddrAck,
  output logic [ADDR_W-1:0] sysAddr,
  output logic [ATTR_W-1:0] sysAttr,
  output logic [DATA_W-1:0] sysData,
  output logic              sysDataAck,
  output logic              sysDataErr
);

  scStrobes_t ctl;

  show_cycle_ctrl #(
    .MIN_REQ_CYC   (MIN_REQ_CYC),
    .GRANT_WAIT_CYC(GRANT_WAIT_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .locValid    (locValid),
    .locAddrAck  (locAddrAck),
    .locQualify  (locQualify),
    .locDone     (locDone),
    .sysGrant    (sysGrant),
    .sysNoShow   (sysNoShow),
    .sysDataBusy (sysDataBusy),
    .ctl         (ctl),
    .locHold     (locHold),
    .sysReq      (sysReq),
    .sysAddrValid(sysAddrValid),
    .sysAddrAck  (sysAddrAck),
    .sysDataAck  (sysDataAck)
  );

  show_cycle_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .ATTR_W(ATTR_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .locAddr   (locAddr),
    .locData   (locData),
    .locAttr   (locAttr),
    .locDataErr(locDataErr),
    .sysAddr   (sysAddr),
    .sysAttr   (sysAttr),
    .sysData   (sysData),
    .sysDataErr(sysDataErr)
  );

endmodule

// File: rtl/show_cycle_checker.sv
module show_cycle_checker (
  input logic clk,
  input logic rst,
  input logic locHold,
  input logic sysReq,
  input logic sysNoShow,
  input logic sysDataBusy,
  input logic sysAddrValid,
  input logic sysDataAck,
  input logic sysDataErr
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!locHold && !sysReq && !sysAddrValid && !sysDataAck));

  p_hold_covers_show_r2: assert property (@(posedge clk) disable iff (rst)
    (sysReq || sysAddrValid || sysDataAck) |-> locHold);

  p_err_with_ack_r5: assert property (@(posedge clk) disable iff (rst)
    sysDataErr |-> sysDataAck);

  p_req_min_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sysReq) |=> sysReq);

  p_wait_before_addr_r7: assert property (@(posedge clk) disable iff (rst)
    sysAddrValid |-> ($past(sysReq) && $past(sysReq, 2)));

  p_single_addr_r7: assert property (@(posedge clk) disable iff (rst)
    sysAddrValid |=> !sysAddrValid);

  p_backoff_r8: assert property (@(posedge clk) disable iff (rst)
    (sysReq && sysNoShow) |=> !sysReq ##1 sysReq);

  p_in_order_r9: assert property (@(posedge clk) disable iff (rst)
    sysDataBusy |-> !sysDataAck);

endmodule

bind show_cycle_bridge show_cycle_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .locHold     (locHold),
  .sysReq      (sysReq),
  .sysNoShow   (sysNoShow),
  .sysDataBusy (sysDataBusy),
  .sysAddrValid(sysAddrValid),
  .sysDataAck  (sysDataAck),
  .sysDataErr  (sysDataErr)
);

// File: tb/show_cycle_bridge_tb.sv
module show_cycle_bridge_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic locValid = 0, locAddrAck = 0, locQualify = 0, locDone = 0, locDataErr = 0;
  logic [31:0] locAddr = '0, locData = '0;
  logic [3:0]  locAttr = '0;
  logic sysGrant = 1, sysNoShow = 0, sysDataBusy = 0;
  logic locHold, sysReq, sysAddrValid, sysAddrAck, sysDataAck, sysDataErr;
  logic [31:0] sysAddr, sysData;
  logic [3:0]  sysAttr;

  int compared = 0;
  int mismatched = 0;
  int sysActivity = 0;

  always #5 clk = ~clk;

  show_cycle_bridge u_dut (
    .clk(clk), .rst(rst),
    .locValid(locValid), .locAddrAck(locAddrAck), .locAddr(locAddr),
    .locData(locData), .locAttr(locAttr), .locQualify(locQualify),
    .locDone(locDone), .locDataErr(locDataErr), .locHold(locHold),
    .sysReq(sysReq), .sysGrant(sysGrant), .sysNoShow(sysNoShow),
    .sysDataBusy(sysDataBusy), .sysAddrValid(sysAddrValid),
    .sysAddrAck(sysAddrAck), .sysAddr(sysAddr), .sysAttr(sysAttr),
    .sysData(sysData), .sysDataAck(sysDataAck), .sysDataErr(sysDataErr)
  );

  // Behavioural reference: phase 0 idle, 1 awaiting termination,
  // 2 requesting, 3 post-grant wait, 4 address, 5 data, 6 back-off, 7 release
  int mPh = 0;
  int mReqN = 0;
  int mWaitN = 0;
  logic [31:0] mAddr = '0, mData = '0;
  logic [3:0]  mAttr = '0;
  bit mQual = 0, mErr = 0;

  always @(posedge clk) begin
    if (rst) begin
      mPh = 0; mAddr = '0; mData = '0; mAttr = '0; mErr = 0; mQual = 0;
    end else begin
      case (mPh)
        0: if (locValid && locAddrAck) begin
             mAddr = locAddr; mData = locData; mAttr = locAttr; mQual = locQualify;
             mReqN = 0;
             if (locDone) begin mErr = locDataErr; mPh = mQual ? 2 : 7; end
             else mPh = 1;
           end
        1: if (locDone) begin mErr = locDataErr; mReqN = 0; mPh = mQual ? 2 : 7; end
        2: begin
             mReqN++;
             if (sysNoShow) mPh = 6;
             else if (sysGrant && mReqN >= 2) begin mPh = 3; mWaitN = 0; end
           end
        3: begin
             mWaitN++;
             if (sysNoShow) mPh = 6;
             else if (mWaitN >= 2) mPh = 4;
           end
        4: mPh = 5;
        5: if (!sysDataBusy) mPh = 7;
        6: begin mPh = 2; mReqN = 0; end
        default: mPh = 0;
      endcase
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (!rst) begin
      if (sysReq || sysAddrValid || sysDataAck) sysActivity++;
      cmp("R2 locHold", 32'(locHold), 32'(mPh != 0));
      cmp("R6 sysReq", 32'(sysReq), 32'(mPh == 2 || mPh == 3));
      cmp("R7 sysAddrValid", 32'(sysAddrValid), 32'(mPh == 4));
      cmp("R7 sysAddrAck", 32'(sysAddrAck), 32'(mPh == 4));
      cmp("R4 sysAddr", sysAddr, (mPh == 4) ? mAddr : 32'h0);
      cmp("R4 sysAttr", 32'(sysAttr), (mPh == 4) ? 32'(mAttr) : 32'h0);
      cmp("R4 sysData", sysData, (mPh == 5) ? mData : 32'h0);
      cmp("R9 sysDataAck", 32'(sysDataAck), 32'(mPh == 5 && !sysDataBusy));
      cmp("R5 sysDataErr", 32'(sysDataErr), 32'(mPh == 5 && !sysDataBusy && mErr));
    end
  end

  task automatic clearLoc();
    locValid = 0; locAddrAck = 0; locDone = 0; locDataErr = 0; locQualify = 0;
  endtask

  // Accepted access; termination arrives dly clocks after the acknowledge
  task automatic access(logic [31:0] a, logic [31:0] d, logic [3:0] at,
                        bit q, int dly, bit e);
    @(negedge clk);
    locValid = 1; locAddrAck = 1; locAddr = a; locData = d; locAttr = at;
    locQualify = q; locDone = (dly == 0); locDataErr = e;
    @(negedge clk);
    if (dly > 0) begin
      clearLoc();
      locAddr = ~a; locData = ~d; locAttr = ~at;
      for (int i = 1; i < dly; i++) @(negedge clk);
      locDone = 1; locDataErr = e;
      @(negedge clk);
    end
    clearLoc();
    locAddr = 32'hDEAD_0000; locData = 32'hBAD0_0000;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 100 && mPh != 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    cmp("R1 reset locHold", 32'(locHold), 0);
    cmp("R1 reset sysReq", 32'(sysReq), 0);
    cmp("R1 reset sysAddr", sysAddr, 0);

    // R4/R5: one-clock local slave, immediate grant
    access(32'h1000_0040, 32'hCAFE_0001, 4'h5, 1, 0, 0);
    waitIdle();

    // R3: retry without acknowledge is not taken, then acknowledged
    @(negedge clk);
    locValid = 1; locAddrAck = 0; locAddr = 32'h2222_0000; locQualify = 1;
    @(negedge clk);
    #2 cmp("R3 retry no hold", 32'(locHold), 0);
    clearLoc();
    access(32'h3333_0008, 32'h0000_BEEF, 4'hA, 1, 0, 0);
    for (int i = 0; i < 20 && !sysAddrValid; i++) begin @(negedge clk); #3; end
    cmp("R3 acked address used", sysAddr, 32'h3333_0008);
    waitIdle();

    // R5: slow termination with data error, delayed grant (R6)
    sysGrant = 0;
    access(32'h4444_0010, 32'h1234_5678, 4'h3, 1, 3, 1);
    repeat (3) @(negedge clk);
    sysGrant = 1;
    for (int i = 0; i < 20 && !sysDataAck; i++) begin @(negedge clk); #3; end
    cmp("R5 error with ack", 32'(sysDataErr), 1);
    waitIdle();

    // R8: no-show veto during request
    access(32'h5555_0020, 32'h0F0F_0F0F, 4'h1, 1, 0, 0);
    @(negedge clk);
    sysNoShow = 1;
    @(negedge clk);
    sysNoShow = 0;
    #2 cmp("R8 request dropped", 32'(sysReq), 0);
    @(negedge clk);
    #2 cmp("R8 request resumed", 32'(sysReq), 1);
    waitIdle();

    // R8: veto during post-grant wait
    access(32'h5656_0024, 32'h7777_0000, 4'h2, 1, 0, 1);
    repeat (3) @(negedge clk);
    sysNoShow = 1;
    @(negedge clk);
    sysNoShow = 0;
    waitIdle();

    // R9: earlier data phase still open
    sysDataBusy = 1;
    access(32'h6666_0030, 32'hAAAA_5555, 4'h6, 1, 1, 0);
    repeat (8) @(negedge clk);
    #2 cmp("R9 no ack while busy", 32'(sysDataAck), 0);
    @(negedge clk);
    sysDataBusy = 0;
    waitIdle();

    // R10: non-qualifying access
    sysActivity = 0;
    access(32'h7777_0040, 32'h1111_1111, 4'h7, 0, 2, 1);
    waitIdle();
    cmp("R10 no system activity", 32'(sysActivity), 0);

    // R11: overlapping access ignored while busy
    sysGrant = 0;
    access(32'h8888_0050, 32'h2222_2222, 4'h8, 1, 0, 0);
    @(negedge clk);
    locValid = 1; locAddrAck = 1; locAddr = 32'h9999_0060; locQualify = 1; locDone = 1;
    @(negedge clk);
    clearLoc();
    sysGrant = 1;
    for (int i = 0; i < 20 && !sysAddrValid; i++) begin @(negedge clk); #3; end
    cmp("R11 first address kept", sysAddr, 32'h8888_0050);
    waitIdle();
    repeat (3) @(negedge clk);
    cmp("R11 second access not replayed", 32'(locHold), 0);

    // R1: reset in the middle of a show cycle
    access(32'hABCD_0070, 32'h3C3C_3C3C, 4'h9, 1, 0, 0);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #2 cmp("R1 mid-cycle reset hold", 32'(locHold), 0);
    cmp("R1 mid-cycle reset req", 32'(sysReq), 0);
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule